// File: doc/BRIEF.md
# Machine-Mode Trap and CSR Unit

This block holds the machine-level control and status registers of a single-hart 32-bit core and runs the trap sequence. The execute stage presents the PC of the instruction it holds on `ex_pc`. A CSR access carries a 12-bit address and a full write value. A read is answered combinationally on `csr_rdata`, and a write is committed at the next clock edge.

A trap is taken for three reasons: an exception request from elsewhere in the pipeline (`exc_valid` with a cause code), an illegal CSR access, or a shift-left-immediate whose shift field has its sixth bit set. In each case the trap registers are loaded at the clock edge. One cycle later the unit presents a redirect to the trap vector. A return request restores the interrupt-enable stack and redirects to the saved exception PC. Only direct trap mode is supported.

The redirect sequencer has three states. RUN means no redirect is pending. ENTER means a trap was taken on the previous edge. RETURN means a return was taken on the previous edge. From any state, a trap moves the sequencer to ENTER and records the trap vector as the target. Otherwise a return moves it to RETURN and records the saved exception PC as the target. Otherwise it goes to RUN. A redirect is shown while the state is ENTER or RETURN.

Top module: `mtrap_unit`

## Requirements
- R1: After reset: mstatus reads 0x0000_1800, mtvec reads RESET_TVEC (default 0x0000_0100), mepc, mcause, mtval and mscratch read 0, and `redirect_valid` is 0.
- R2: misa (0x301) reads 0x4000_0100, with bit 30 marking 32-bit width. misa, medeleg (0x302), mcounteren (0x306) and mip (0x344) accept writes without effect and without a trap; the last three read 0. mstatus (0x300) stores only MIE (bit 3) and MPIE (bit 7), and MPP (bits 12:11) always reads 3.
- R3: The identification registers 0xF11, 0xF12, 0xF13 and 0xF14 read 0. A write to any of them, or to any address whose bits 11:10 are both 1, raises cause 2.
- R4: An access to an address outside the map reads 0 and raises cause 2.
- R5: mscratch (0x340), mcause (0x342) and mtval (0x343) store all 32 bits. mtvec (0x305) and mepc (0x341) read bits 1:0 as 0.
- R6: On a trap, at the next edge mepc takes `ex_pc` with bits 1:0 cleared, mtval takes `ex_pc` unchanged, and mcause takes the cause zero-extended. The cause codes are: 0 fetch misaligned, 1 fetch access fault, 2 illegal instruction, 3 breakpoint, 4 load misaligned, 5 load access fault.
- R7: On a trap, MPIE takes the old MIE, MIE becomes 0, and MPP stays 3.
- R8: In the cycle after a trap request, `redirect_valid` is 1 for exactly one cycle and `redirect_pc` equals the mtvec value held before that edge.
- R9: On a return request with no trap, the next cycle shows a redirect to mepc. MIE takes MPIE and MPIE becomes 1.
- R10: An instruction with opcode 0010011 and funct3 001 is a shift-left-immediate. If bit 25 is 1, `rd_we` is 0 and cause 2 is raised. Otherwise `rd_we` is 1 and `shamt` shows bits 24:20.
- R11: An external exception's cause takes priority over cause 2 from other sources. A trap in a cycle discards any CSR write and any return request in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ex_pc | input | 32 | PC of the instruction in execute |
| exc_valid | input | 1 | External exception request, one cycle |
| exc_cause | input | CAUSE_W | Cause of the external exception |
| csr_valid | input | 1 | CSR access this cycle |
| csr_write | input | 1 | The access is a write |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 32 | Value to write |
| csr_rdata | output | 32 | Read value (combinational) |
| mret_valid | input | 1 | Return-from-trap request |
| ins_valid | input | 1 | Instruction word is valid |
| ins_word | input | 32 | Instruction word to screen |
| rd_we | output | 1 | Shift result may be written |
| shamt | output | 5 | Shift amount |
| redirect_valid | output | 1 | Fetch redirect this cycle |
| redirect_pc | output | 32 | Redirect target |

## Verification
On every cycle, the assertions check the effects of a trap on the next edge: the saved PC, the enable stack, the redirect to the old vector, and that mtvec survives an attempted write. They also check the effects of a return, that no redirect appears without a cause, and that the illegal shift form never enables the register write. Only the bench scenarios can show the values read back across the address map and the discarded writes to the read-only registers. The bench also checks which cause wins when several sources coincide, and that mscratch keeps its value when a write arrives alongside a trap.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;

    localparam int XLEN = 32;

    localparam logic [11:0] A_STATUS  = 12'h300;
    localparam logic [11:0] A_ISA     = 12'h301;
    localparam logic [11:0] A_EDELEG  = 12'h302;
    localparam logic [11:0] A_TVEC    = 12'h305;
    localparam logic [11:0] A_CNTEN   = 12'h306;
    localparam logic [11:0] A_SCRATCH = 12'h340;
    localparam logic [11:0] A_EPC     = 12'h341;
    localparam logic [11:0] A_CAUSE   = 12'h342;
    localparam logic [11:0] A_TVAL    = 12'h343;
    localparam logic [11:0] A_IP      = 12'h344;

    localparam logic [3:0] CAUSE_FETCH_MISALIGN = 4'd0;
    localparam logic [3:0] CAUSE_FETCH_FAULT    = 4'd1;
    localparam logic [3:0] CAUSE_ILLEGAL        = 4'd2;
    localparam logic [3:0] CAUSE_BREAK          = 4'd3;
    localparam logic [3:0] CAUSE_LOAD_MISALIGN  = 4'd4;
    localparam logic [3:0] CAUSE_LOAD_FAULT     = 4'd5;

    localparam int ST_MIE  = 3;
    localparam int ST_MPIE = 7;

    localparam logic [6:0] OPC_OPIMM   = 7'b0010011;
    localparam logic [2:0] F3_SHL      = 3'b001;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_ISA,
        SEL_EDELEG,
        SEL_TVEC,
        SEL_CNTEN,
        SEL_SCRATCH,
        SEL_EPC,
        SEL_CAUSE,
        SEL_TVAL,
        SEL_IP,
        SEL_IDENT
    } csr_sel_e;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_ENTER,
        ST_RETURN
    } seq_state_e;

endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode
    import mtrap_pkg::*;
(
    input  logic        acc_valid,
    input  logic        acc_write,
    input  logic [11:0] acc_addr,
    output csr_sel_e    acc_sel,
    output logic        acc_illegal
);

    logic read_only;

    always_comb begin
        unique case (acc_addr)
            A_STATUS:  acc_sel = SEL_STATUS;
            A_ISA:     acc_sel = SEL_ISA;
            A_EDELEG:  acc_sel = SEL_EDELEG;
            A_TVEC:    acc_sel = SEL_TVEC;
            A_CNTEN:   acc_sel = SEL_CNTEN;
            A_SCRATCH: acc_sel = SEL_SCRATCH;
            A_EPC:     acc_sel = SEL_EPC;
            A_CAUSE:   acc_sel = SEL_CAUSE;
            A_TVAL:    acc_sel = SEL_TVAL;
            A_IP:      acc_sel = SEL_IP;
            12'hF11, 12'hF12, 12'hF13, 12'hF14:
                       acc_sel = SEL_IDENT;
            default:   acc_sel = SEL_NONE;
        endcase
    end

    // the top two address bits both set mark a read-only register
    assign read_only   = &acc_addr[11:10];
    assign acc_illegal = acc_valid &
                         ((acc_sel == SEL_NONE) | (acc_write & read_only));

endmodule

// File: rtl/slli_screen.sv
module slli_screen
    import mtrap_pkg::*;
(
    input  logic        ins_valid,
    input  logic [31:0] ins_word,
    output logic        shl_hit,
    output logic        shl_illegal,
    output logic        shl_we,
    output logic [4:0]  shl_amt
);

    logic unused_fields;

    assign shl_hit     = ins_valid &
                         (ins_word[6:0] == OPC_OPIMM) &
                         (ins_word[14:12] == F3_SHL);
    assign shl_illegal = shl_hit & ins_word[25];
    assign shl_we      = shl_hit & ~ins_word[25];
    assign shl_amt     = ins_word[24:20];

    assign unused_fields = ^{ins_word[31:26], ins_word[19:15], ins_word[11:7]};

endmodule

// File: rtl/csr_regfile.sv
module csr_regfile
    import mtrap_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_TVEC = 32'h0000_0100,
    parameter logic [XLEN-1:0] ISA_EXT    = 32'h0000_0100,
    parameter int              CAUSE_W    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  csr_sel_e           sel,
    input  logic               wr_en,
    input  logic [XLEN-1:0]    wdata,
    input  logic               trap_en,
    input  logic [CAUSE_W-1:0] trap_cause,
    input  logic [XLEN-1:0]    trap_pc,
    input  logic               ret_en,
    output logic [XLEN-1:0]    rdata,
    output logic [XLEN-1:0]    tvec,
    output logic [XLEN-1:0]    epc,
    output logic               mie,
    output logic               mpie
);

    localparam logic [XLEN-1:0] ISA_VAL = (32'h1 << 30) | ISA_EXT;

    logic              mie_q, mpie_q;
    logic [XLEN-1:2]   tvec_q, epc_q;
    logic [XLEN-1:0]   cause_q, tval_q, scratch_q;
    logic [XLEN-1:0]   status_rd;
    logic              unused_low;

    assign status_rd = {19'b0, 2'b11, 3'b0, mpie_q, 3'b0, mie_q, 3'b0};
    assign tvec      = {tvec_q, 2'b00};
    assign epc       = {epc_q, 2'b00};
    assign mie       = mie_q;
    assign mpie      = mpie_q;
    assign unused_low = ^{wdata[1:0], trap_pc[1:0]};

    always_comb begin
        unique case (sel)
            SEL_STATUS:  rdata = status_rd;
            SEL_ISA:     rdata = ISA_VAL;
            SEL_TVEC:    rdata = tvec;
            SEL_SCRATCH: rdata = scratch_q;
            SEL_EPC:     rdata = epc;
            SEL_CAUSE:   rdata = cause_q;
            SEL_TVAL:    rdata = tval_q;
            default:     rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mie_q     <= 1'b0;
            mpie_q    <= 1'b0;
            tvec_q    <= RESET_TVEC[XLEN-1:2];
            epc_q     <= '0;
            cause_q   <= '0;
            tval_q    <= '0;
            scratch_q <= '0;
        end else if (trap_en) begin
            mpie_q  <= mie_q;
            mie_q   <= 1'b0;
            epc_q   <= trap_pc[XLEN-1:2];
            tval_q  <= trap_pc;
            cause_q <= XLEN'(trap_cause);
        end else if (ret_en) begin
            mie_q  <= mpie_q;
            mpie_q <= 1'b1;
        end else if (wr_en) begin
            unique case (sel)
                SEL_STATUS: begin
                    mie_q  <= wdata[ST_MIE];
                    mpie_q <= wdata[ST_MPIE];
                end
                SEL_TVEC:    tvec_q    <= wdata[XLEN-1:2];
                SEL_SCRATCH: scratch_q <= wdata;
                SEL_EPC:     epc_q     <= wdata[XLEN-1:2];
                SEL_CAUSE:   cause_q   <= wdata;
                SEL_TVAL:    tval_q    <= wdata;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/trap_fsm.sv
module trap_fsm
    import mtrap_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trap_en,
    input  logic            ret_en,
    input  logic [XLEN-1:0] tvec,
    input  logic [XLEN-1:0] epc,
    output logic            redirect_valid,
    output logic [XLEN-1:0] redirect_pc
);

    seq_state_e      state_q, state_d;
    logic [XLEN-1:0] target_q, target_d;

    always_comb begin
        if (trap_en) begin
            state_d  = ST_ENTER;
            target_d = tvec;
        end else if (ret_en) begin
            state_d  = ST_RETURN;
            target_d = epc;
        end else begin
            state_d  = ST_RUN;
            target_d = target_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_RUN;
            target_q <= '0;
        end else begin
            state_q  <= state_d;
            target_q <= target_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_ENTER, ST_RETURN: begin
                redirect_valid = 1'b1;
                redirect_pc    = target_q;
            end
            default: begin
                redirect_valid = 1'b0;
                redirect_pc    = '0;
            end
        endcase
    end

endmodule

// File: rtl/mtrap_unit.sv
module mtrap_unit
    import mtrap_pkg::*;
#(
    parameter logic [31:0] RESET_TVEC = 32'h0000_0100,
    parameter logic [31:0] ISA_EXT    = 32'h0000_0100,
    parameter int          CAUSE_W    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [31:0]        ex_pc,
    input  logic               exc_valid,
    input  logic [CAUSE_W-1:0] exc_cause,
    input  logic               csr_valid,
    input  logic               csr_write,
    input  logic [11:0]        csr_addr,
    input  logic [31:0]        csr_wdata,
    output logic [31:0]        csr_rdata,
    input  logic               mret_valid,
    input  logic               ins_valid,
    input  logic [31:0]        ins_word,
    output logic               rd_we,
    output logic [4:0]         shamt,
    output logic               redirect_valid,
    output logic [31:0]        redirect_pc
);

    csr_sel_e           sel;
    logic               csr_illegal, slli_hit, slli_illegal;
    logic               trap_take, mret_take, wr_take;
    logic [CAUSE_W-1:0] trap_cause;
    logic [31:0]        tvec_w, epc_w;
    logic               mie_w, mpie_w;

    csr_addr_decode u_dec (
        .acc_valid   (csr_valid),
        .acc_write   (csr_write),
        .acc_addr    (csr_addr),
        .acc_sel     (sel),
        .acc_illegal (csr_illegal)
    );

    slli_screen u_shl (
        .ins_valid   (ins_valid),
        .ins_word    (ins_word),
        .shl_hit     (slli_hit),
        .shl_illegal (slli_illegal),
        .shl_we      (rd_we),
        .shl_amt     (shamt)
    );

    assign trap_take  = exc_valid | csr_illegal | slli_illegal;
    assign trap_cause = exc_valid ? exc_cause : CAUSE_W'(CAUSE_ILLEGAL);
    assign mret_take  = mret_valid & ~trap_take;
    assign wr_take    = csr_valid & csr_write & ~csr_illegal;

    csr_regfile #(
        .RESET_TVEC (RESET_TVEC),
        .ISA_EXT    (ISA_EXT),
        .CAUSE_W    (CAUSE_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (sel),
        .wr_en      (wr_take),
        .wdata      (csr_wdata),
        .trap_en    (trap_take),
        .trap_cause (trap_cause),
        .trap_pc    (ex_pc),
        .ret_en     (mret_take),
        .rdata      (csr_rdata),
        .tvec       (tvec_w),
        .epc        (epc_w),
        .mie        (mie_w),
        .mpie       (mpie_w)
    );

    trap_fsm u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .trap_en        (trap_take),
        .ret_en         (mret_take),
        .tvec           (tvec_w),
        .epc            (epc_w),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc)
    );

endmodule

// File: rtl/mtrap_unit_chk.sv
module mtrap_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        trap_take,
    input logic        mret_take,
    input logic        exc_valid,
    input logic [31:0] ex_pc,
    input logic [31:0] tvec_w,
    input logic [31:0] epc_w,
    input logic        mie_w,
    input logic        mpie_w,
    input logic        slli_hit,
    input logic [31:0] ins_word,
    input logic        rd_we,
    input logic        redirect_valid,
    input logic [31:0] redirect_pc
);

    // R8
    trap_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> redirect_valid && redirect_pc == $past(tvec_w));

    // R6
    trap_epc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> epc_w == {$past(ex_pc[31:2]), 2'b00});

    // R7
    trap_stack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> !mie_w && (mpie_w == $past(mie_w)));

    // R9
    ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mret_take |=> redirect_valid && redirect_pc == $past(epc_w)
                      && mie_w == $past(mpie_w) && mpie_w);

    // R8
    no_spurious_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_take && !mret_take |=> !redirect_valid);

    // R10
    shl_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slli_hit && ins_word[25] |-> !rd_we);

    // R11
    tvec_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> $stable(tvec_w));

endmodule

bind mtrap_unit mtrap_unit_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .trap_take      (trap_take),
    .mret_take      (mret_take),
    .exc_valid      (exc_valid),
    .ex_pc          (ex_pc),
    .tvec_w         (tvec_w),
    .epc_w          (epc_w),
    .mie_w          (mie_w),
    .mpie_w         (mpie_w),
    .slli_hit       (slli_hit),
    .ins_word       (ins_word),
    .rd_we          (rd_we),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc)
);

// File: tb/mtrap_unit_test.sv
`timescale 1ns/1ps
module mtrap_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ex_pc = '0;
    logic        exc_valid = 1'b0;
    logic [3:0]  exc_cause = '0;
    logic        csr_valid = 1'b0;
    logic        csr_write = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        mret_valid = 1'b0;
    logic        ins_valid = 1'b0;
    logic [31:0] ins_word = '0;
    logic        rd_we;
    logic [4:0]  shamt;
    logic        redirect_valid;
    logic [31:0] redirect_pc;

    int applied = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mtrap_unit uut (
        .clk(clk), .rst_n(rst_n), .ex_pc(ex_pc),
        .exc_valid(exc_valid), .exc_cause(exc_cause),
        .csr_valid(csr_valid), .csr_write(csr_write), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .mret_valid(mret_valid),
        .ins_valid(ins_valid), .ins_word(ins_word), .rd_we(rd_we), .shamt(shamt),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
    );

    // {address, write value, expected read-back}
    localparam int NV = 11;
    localparam logic [75:0] VEC [NV] = '{
        {12'h340, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
        {12'h305, 32'h8000_0103, 32'h8000_0100},
        {12'h341, 32'h1234_5677, 32'h1234_5674},
        {12'h342, 32'h8000_000B, 32'h8000_000B},
        {12'h343, 32'hCAFE_F00D, 32'hCAFE_F00D},
        {12'h301, 32'hFFFF_FFFF, 32'h4000_0100},
        {12'h302, 32'hFFFF_FFFF, 32'h0000_0000},
        {12'h306, 32'hFFFF_FFFF, 32'h0000_0000},
        {12'h344, 32'hFFFF_FFFF, 32'h0000_0000},
        {12'h300, 32'hFFFF_FF88, 32'h0000_1888},
        {12'h300, 32'h0000_0000, 32'h0000_1800}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        applied++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic csr_rd(input logic [11:0] a, output logic [31:0] v);
        csr_valid = 1'b1; csr_write = 1'b0; csr_addr = a;
        #1 v = csr_rdata;
        csr_valid = 1'b0;
    endtask

    task automatic csr_wr(input logic [11:0] a, input logic [31:0] d);
        csr_valid = 1'b1; csr_write = 1'b1; csr_addr = a; csr_wdata = d;
        tick();
        csr_valid = 1'b0; csr_write = 1'b0;
    endtask

    task automatic clear_in();
        exc_valid = 1'b0; csr_valid = 1'b0; csr_write = 1'b0;
        mret_valid = 1'b0; ins_valid = 1'b0;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 redirect_valid", {31'b0, redirect_valid}, 32'h0);
        csr_rd(12'h300, v); check("R1 mstatus", v, 32'h0000_1800);
        csr_rd(12'h305, v); check("R1 mtvec", v, 32'h0000_0100);
        csr_rd(12'h341, v); check("R1 mepc", v, 32'h0);
        csr_rd(12'h342, v); check("R1 mcause", v, 32'h0);
        csr_rd(12'h343, v); check("R1 mtval", v, 32'h0);
        csr_rd(12'h340, v); check("R1 mscratch", v, 32'h0);
        @(negedge clk);

        // R5 / R2 write and read-back table
        for (int i = 0; i < NV; i++) begin
            csr_wr(VEC[i][75:64], VEC[i][63:32]);
            check(i < 5 ? "R5 no trap" : "R2 no trap", {31'b0, redirect_valid}, 32'h0);
            csr_rd(VEC[i][75:64], v);
            check(i < 5 ? "R5 readback" : "R2 readback", v, VEC[i][31:0]);
        end

        // R6 R7 R8 trap entry with MIE set
        csr_wr(12'h300, 32'h0000_0008);
        exc_valid = 1'b1; exc_cause = 4'd5; ex_pc = 32'h0000_2006;
        tick(); clear_in(); #1;
        check("R8 redirect_valid", {31'b0, redirect_valid}, 32'h1);
        check("R8 redirect_pc", redirect_pc, 32'h8000_0100);
        csr_rd(12'h341, v); check("R6 mepc", v, 32'h0000_2004);
        csr_rd(12'h343, v); check("R6 mtval", v, 32'h0000_2006);
        csr_rd(12'h342, v); check("R6 mcause", v, 32'h5);
        csr_rd(12'h300, v); check("R7 mstatus", v, 32'h0000_1880);
        tick(); #1;
        check("R8 single cycle", {31'b0, redirect_valid}, 32'h0);

        // R9 return
        mret_valid = 1'b1;
        tick(); clear_in(); #1;
        check("R9 redirect_valid", {31'b0, redirect_valid}, 32'h1);
        check("R9 redirect_pc", redirect_pc, 32'h0000_2004);
        csr_rd(12'h300, v); check("R9 mstatus", v, 32'h0000_1888);
        tick();

        // R3 identification registers
        csr_rd(12'hF11, v); check("R3 id read", v, 32'h0);
        tick(); #1;
        check("R3 id read no trap", {31'b0, redirect_valid}, 32'h0);
        ex_pc = 32'h0000_0500;
        csr_valid = 1'b1; csr_write = 1'b1; csr_addr = 12'hF12; csr_wdata = 32'h1;
        tick(); clear_in(); #1;
        check("R3 id write trap", {31'b0, redirect_valid}, 32'h1);
        check("R3 id write target", redirect_pc, 32'h8000_0100);
        csr_rd(12'h342, v); check("R3 mcause", v, 32'h2);
        csr_rd(12'h341, v); check("R3 mepc", v, 32'h0000_0500);
        tick();

        // R4 unmapped address
        ex_pc = 32'h0000_0600;
        csr_valid = 1'b1; csr_write = 1'b0; csr_addr = 12'h7C0;
        #1 check("R4 unmapped read", csr_rdata, 32'h0);
        tick(); clear_in(); #1;
        check("R4 trap", {31'b0, redirect_valid}, 32'h1);
        csr_rd(12'h342, v); check("R4 mcause", v, 32'h2);
        tick();

        // R10 legal shift
        ins_valid = 1'b1;
        ins_word = {7'b0, 5'd7, 5'd1, 3'b001, 5'd5, 7'b0010011};
        #1;
        check("R10 legal rd_we", {31'b0, rd_we}, 32'h1);
        check("R10 shamt", {27'b0, shamt}, 32'd7);
        tick(); clear_in(); #1;
        check("R10 legal no trap", {31'b0, redirect_valid}, 32'h0);

        // R10 illegal shift
        ex_pc = 32'h0000_0700;
        ins_valid = 1'b1;
        ins_word = {6'b0, 1'b1, 5'd3, 5'd1, 3'b001, 5'd5, 7'b0010011};
        #1 check("R10 illegal rd_we", {31'b0, rd_we}, 32'h0);
        tick(); clear_in(); #1;
        check("R10 illegal trap", {31'b0, redirect_valid}, 32'h1);
        csr_rd(12'h342, v); check("R10 mcause", v, 32'h2);
        tick();

        // R11 trap beats CSR write and return
        ex_pc = 32'h0000_3000;
        exc_valid = 1'b1; exc_cause = 4'd3; mret_valid = 1'b1;
        csr_valid = 1'b1; csr_write = 1'b1; csr_addr = 12'h340; csr_wdata = 32'h1111_1111;
        tick(); clear_in(); #1;
        check("R11 redirect to vector", redirect_pc, 32'h8000_0100);
        csr_rd(12'h340, v); check("R11 mscratch kept", v, 32'hDEAD_BEEF);
        csr_rd(12'h342, v); check("R11 mcause", v, 32'h3);
        tick();

        // R11 external cause beats illegal shift
        ex_pc = 32'h0000_4000;
        exc_valid = 1'b1; exc_cause = 4'd0;
        ins_valid = 1'b1;
        ins_word = {6'b0, 1'b1, 5'd3, 5'd1, 3'b001, 5'd5, 7'b0010011};
        tick(); clear_in(); #1;
        csr_rd(12'h342, v); check("R11 cause priority", v, 32'h0);

        // R11 trap with mtvec write keeps mtvec
        tick();
        exc_valid = 1'b1; exc_cause = 4'd1;
        csr_valid = 1'b1; csr_write = 1'b1; csr_addr = 12'h305; csr_wdata = 32'h0000_0400;
        tick(); clear_in(); #1;
        csr_rd(12'h305, v); check("R11 mtvec kept", v, 32'h8000_0100);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            applied++;
            miscompares++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
            $finish;
        end
    end

endmodule